// File: doc/BRIEF.md
# Privilege status register unit

This block keeps the 16-bit processor status word and chooses which of three banked stack pointers answers as the stack register. The low byte carries the five condition flags. The upper byte carries the interrupt priority mask, a stack-select bit, the privilege bit and two trace-control bits. Software-visible writes arrive as full-word or low-byte requests. An external flag unit may also refresh the condition flags on their own. Exception entry and return-from-exception events move the word between privilege levels.

The block drives the privilege level, the interrupt mask, the effective trace mode and the active stack select from its registered state. It also presents the status word as it stood before the last exception entry, so that the word can be pushed. A privileged request made from user mode is refused. The refusal shows as a one-cycle violation pulse. Instruction decode, vectoring and flag arithmetic are done elsewhere.

Top module: `status_priv_unit`

## Requirements
- R1: Bits 0..4 of the status word are, from bit 0 upward, carry, overflow, zero, negative and extend. A `flag_upd` request copies `flag_in[4:0]` into those bits, bit for bit, in the next cycle.
- R2: Bits 5, 6, 7 and 11 of `status_word` always read 0, whatever value is written.
- R3: Bits 10..8 hold the interrupt priority mask, and `irq_mask` shows them.
- R4: Bit 13 is the privilege bit (1 = supervisor) and `is_super` shows it. Bit 12 chooses the master stack (1) or the interrupt stack (0) while in supervisor mode. `sp_sel` is 0 for user, 1 for interrupt and 2 for master.
- R5: Bits 15..14 are the trace control: 00 none, 10 every instruction, 01 change of flow only. A stored 11 is kept in the word. In that case `trace_mode` reads 00 and `trace_illegal` reads 1.
- R6: A full-word write made in user mode leaves the word unchanged and raises `priv_viol` for exactly one cycle, the cycle after the request.
- R7: A stack write or read goes to the user pointer in user mode. In supervisor mode it goes to the interrupt or master pointer, as bit 12 selects. The selection uses the word held in the cycle of the request, and `sp_rdata` shows the active pointer.
- R8: Exception entry sets bit 13 and clears bits 15..14, and leaves every other bit as it was, whatever the prior mode.
- R9: The cycle after an exception entry, `saved_word` holds the status word from before the entry. It keeps that value until the next entry.
- R10: A return-from-exception in supervisor mode loads `ret_word` (reserved bits zeroed). In user mode the return is refused like R6.
- R11: After reset the word is 16'h2700: supervisor, mask 7, interrupt stack, no trace, flags clear. All stack pointers and `saved_word` are 0 and `priv_viol` is low.
- R12: When requests meet in one cycle, only the first of exception entry, return, full write, low-byte write, flag update takes effect. A low-byte write is allowed in either mode and zeroes bits 7..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_full | input | 1 | Write the whole status word (privileged) |
| wr_low | input | 1 | Write the condition byte only |
| wr_data | input | 16 | Data for either write |
| flag_upd | input | 1 | Refresh flags from the flag unit |
| flag_in | input | 5 | New flag values, carry at bit 0 |
| exc_enter | input | 1 | Exception entry event |
| exc_return | input | 1 | Return-from-exception event |
| ret_word | input | 16 | Status word restored on return |
| sp_wr | input | 1 | Write the active stack pointer |
| sp_wdata | input | SP_W | Stack pointer write data |
| status_word | output | 16 | Current status word |
| saved_word | output | 16 | Status word before the last entry |
| is_super | output | 1 | Supervisor mode |
| irq_mask | output | 3 | Interrupt priority mask |
| trace_mode | output | 2 | Effective trace control |
| trace_illegal | output | 1 | Stored trace code is 11 |
| sp_sel | output | 2 | Active stack: 0 user, 1 interrupt, 2 master |
| sp_rdata | output | SP_W | Active stack pointer value |
| priv_viol | output | 1 | Privilege violation pulse |

## Verification
The bench attempts full-word writes and returns from user mode. A design that lets either through would change the privilege bit or miss the violation pulse. It writes stack data in the same cycle that the mode or the stack select changes. A pointer update that lands in the new bank instead of the old one shows up at once on the read port. It also applies entry together with writes, and stores the reserved trace code 11. A wrong priority ordering, a saved word taken after the update, or trace code 11 acted on as a real mode each breaks the comparison with the cycle-level model.

// File: rtl/psu_pkg.sv
package psu_pkg;
  localparam int WORD_W  = 16;
  localparam int FLAG_W  = 5;
  localparam int MASK_LO = 8;
  localparam int MASK_W  = 3;
  localparam int BIT_MST = 12;
  localparam int BIT_SUP = 13;
  localparam int TRC_LO  = 14;
  localparam int STK_NUM = 3;
  localparam logic [WORD_W-1:0] KEEP_BITS = 16'hF71F;

  typedef enum logic [1:0] {
    STK_USER = 2'd0,
    STK_INTR = 2'd1,
    STK_MSTR = 2'd2
  } stk_sel_e;

  function automatic logic [WORD_W-1:0] legalize(input logic [WORD_W-1:0] w);
    return w & KEEP_BITS;
  endfunction
endpackage

// File: rtl/psu_word_reg.sv
module psu_word_reg
  import psu_pkg::*;
#(
  parameter int RST_MASK = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_full,
  input  logic              wr_low,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              flag_upd,
  input  logic [FLAG_W-1:0] flag_in,
  input  logic              exc_enter,
  input  logic              exc_return,
  input  logic [WORD_W-1:0] ret_word,
  output logic [WORD_W-1:0] status_q,
  output logic [WORD_W-1:0] saved_q,
  output logic              viol_q
);
  localparam logic [WORD_W-1:0] RST_WORD =
    WORD_W'(1 << BIT_SUP) | WORD_W'((RST_MASK % 8) << MASK_LO);

  logic [WORD_W-1:0] nxt;
  logic              viol_d;
  logic              save_d;
  logic              sup;

  assign sup = status_q[BIT_SUP];

  always_comb begin
    nxt    = status_q;
    viol_d = 1'b0;
    save_d = 1'b0;
    if (exc_enter) begin
      save_d                 = 1'b1;
      nxt[BIT_SUP]           = 1'b1;
      nxt[TRC_LO +: 2]       = 2'b00;
    end else if (exc_return) begin
      if (sup) nxt = legalize(ret_word);
      else     viol_d = 1'b1;
    end else if (wr_full) begin
      if (sup) nxt = legalize(wr_data);
      else     viol_d = 1'b1;
    end else if (wr_low) begin
      nxt[7:0] = {3'b000, wr_data[FLAG_W-1:0]};
    end else if (flag_upd) begin
      nxt[FLAG_W-1:0] = flag_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= RST_WORD;
      saved_q  <= '0;
      viol_q   <= 1'b0;
    end else begin
      status_q <= nxt;
      viol_q   <= viol_d;
      if (save_d) saved_q <= status_q;
    end
  end

  AST_USER_FULL_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!status_q[BIT_SUP] && wr_full && !exc_enter && !exc_return)
      |=> ($stable(status_q) && viol_q)); // R6

  AST_ENTRY_SUPER: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (status_q[BIT_SUP] && status_q[TRC_LO +: 2] == 2'b00)); // R8

  AST_ENTRY_SAVE: assert property (@(posedge clk) disable iff (rst)
    exc_enter |=> (saved_q == $past(status_q))); // R9

  AST_USER_RET_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!status_q[BIT_SUP] && exc_return && !exc_enter)
      |=> ($stable(status_q) && viol_q)); // R10
endmodule

// File: rtl/psu_stack_bank.sv
module psu_stack_bank
  import psu_pkg::*;
#(
  parameter int SP_W   = 32,
  parameter int RST_SP = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      sel,
  input  logic            wr_en,
  input  logic [SP_W-1:0] wdata,
  output logic [SP_W-1:0] rdata
);
  logic [SP_W-1:0] bank_q [STK_NUM];

  for (genvar g = 0; g < STK_NUM; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                          bank_q[g] <= SP_W'(RST_SP);
      else if (wr_en && sel == 2'(g))   bank_q[g] <= wdata;
    end
  end

  always_comb begin
    case (sel)
      STK_INTR: rdata = bank_q[1];
      STK_MSTR: rdata = bank_q[2];
      default:  rdata = bank_q[0];
    endcase
  end

  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((sel != $past(sel)) || rdata == $past(wdata))); // R7
endmodule

// File: rtl/psu_view.sv
module psu_view
  import psu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] status,
  output logic              is_super,
  output logic [MASK_W-1:0] irq_mask,
  output logic [1:0]        trace_mode,
  output logic              trace_illegal,
  output logic [1:0]        sp_sel
);
  logic [1:0] trc;
  assign trc           = status[TRC_LO +: 2];
  assign is_super      = status[BIT_SUP];
  assign irq_mask      = status[MASK_LO +: MASK_W];
  assign trace_illegal = (trc == 2'b11);
  assign trace_mode    = trace_illegal ? 2'b00 : trc;

  always_comb begin
    if (!status[BIT_SUP])     sp_sel = STK_USER;
    else if (status[BIT_MST]) sp_sel = STK_MSTR;
    else                      sp_sel = STK_INTR;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst)
    (status[7:5] == 3'b000 && status[11] == 1'b0)); // R2

  AST_TRACE_BAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    trace_illegal |-> (trace_mode == 2'b00)); // R5
endmodule

// File: rtl/status_priv_unit.sv
module status_priv_unit
  import psu_pkg::*;
#(
  parameter int SP_W     = 32,
  parameter int RST_MASK = 7,
  parameter int RST_SP   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_full,
  input  logic             wr_low,
  input  logic [15:0]      wr_data,
  input  logic             flag_upd,
  input  logic [4:0]       flag_in,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [15:0]      ret_word,
  input  logic             sp_wr,
  input  logic [SP_W-1:0]  sp_wdata,
  output logic [15:0]      status_word,
  output logic [15:0]      saved_word,
  output logic             is_super,
  output logic [2:0]       irq_mask,
  output logic [1:0]       trace_mode,
  output logic             trace_illegal,
  output logic [1:0]       sp_sel,
  output logic [SP_W-1:0]  sp_rdata,
  output logic             priv_viol
);
  logic [WORD_W-1:0] st;

  psu_word_reg #(.RST_MASK(RST_MASK)) u_word (
    .clk(clk), .rst(rst),
    .wr_full(wr_full), .wr_low(wr_low), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_in(flag_in),
    .exc_enter(exc_enter), .exc_return(exc_return), .ret_word(ret_word),
    .status_q(st), .saved_q(saved_word), .viol_q(priv_viol)
  );

  psu_view u_view (
    .clk(clk), .rst(rst), .status(st),
    .is_super(is_super), .irq_mask(irq_mask), .trace_mode(trace_mode),
    .trace_illegal(trace_illegal), .sp_sel(sp_sel)
  );

  psu_stack_bank #(.SP_W(SP_W), .RST_SP(RST_SP)) u_bank (
    .clk(clk), .rst(rst), .sel(sp_sel),
    .wr_en(sp_wr), .wdata(sp_wdata), .rdata(sp_rdata)
  );

  assign status_word = st;
endmodule

// File: tb/test_status_priv_unit.sv
module test_status_priv_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_full = 0, wr_low = 0, flag_upd = 0, exc_enter = 0, exc_return = 0, sp_wr = 0;
  logic [15:0] wr_data = 0, ret_word = 0;
  logic [4:0]  flag_in = 0;
  logic [31:0] sp_wdata = 0;
  logic [15:0] status_word, saved_word;
  logic        is_super, trace_illegal, priv_viol;
  logic [2:0]  irq_mask;
  logic [1:0]  trace_mode, sp_sel;
  logic [31:0] sp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit running = 0;

  // reference model state
  logic [15:0] st_m, sv_m;
  logic [31:0] sp_m [3];
  logic        vi_m;

  always #2 clk = ~clk;

  status_priv_unit i_status_priv_unit (
    .clk(clk), .rst(rst), .wr_full(wr_full), .wr_low(wr_low), .wr_data(wr_data),
    .flag_upd(flag_upd), .flag_in(flag_in), .exc_enter(exc_enter),
    .exc_return(exc_return), .ret_word(ret_word), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .status_word(status_word), .saved_word(saved_word), .is_super(is_super),
    .irq_mask(irq_mask), .trace_mode(trace_mode), .trace_illegal(trace_illegal),
    .sp_sel(sp_sel), .sp_rdata(sp_rdata), .priv_viol(priv_viol)
  );

  function automatic int sel_of(input logic [15:0] w);
    if (!w[13]) return 0;
    return w[12] ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      st_m = 16'h2700; sv_m = 0; vi_m = 0;
      for (int i = 0; i < 3; i++) sp_m[i] = 0;
    end else begin
      if (sp_wr) sp_m[sel_of(st_m)] = sp_wdata;
      vi_m = 0;
      if (exc_enter) begin
        sv_m = st_m; st_m[13] = 1'b1; st_m[15:14] = 2'b00;
      end else if (exc_return) begin
        if (st_m[13]) st_m = ret_word & 16'hF71F; else vi_m = 1;
      end else if (wr_full) begin
        if (st_m[13]) st_m = wr_data & 16'hF71F; else vi_m = 1;
      end else if (wr_low) begin
        st_m[7:0] = {3'b000, wr_data[4:0]};
      end else if (flag_upd) begin
        st_m[4:0] = flag_in;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      chk("R1 flags", status_word[4:0], st_m[4:0]);
      chk("R2 reserved", {status_word[11], status_word[7:5]}, 4'h0);
      chk("R3 mask", irq_mask, st_m[10:8]);
      chk("R4 mode/stack bits", {is_super, status_word[13:12]}, {st_m[13], st_m[13:12]});
      chk("R4 sp_sel", sp_sel, sel_of(st_m));
      chk("R5 trace field", status_word[15:14], st_m[15:14]);
      chk("R5 trace out", {trace_illegal, trace_mode},
          (st_m[15:14] == 2'b11) ? 3'b100 : {1'b0, st_m[15:14]});
      chk("R6/R10 violation", priv_viol, vi_m);
      chk("R9 saved", saved_word, sv_m);
      chk("R7 stack read", sp_rdata, sp_m[sel_of(st_m)]);
    end
  end

  task automatic idle();
    wr_full = 0; wr_low = 0; flag_upd = 0; exc_enter = 0; exc_return = 0; sp_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset word", status_word, 16'h2700);
    chk("R11 reset sp", sp_rdata, 0);
    chk("R11 reset viol/saved", {priv_viol, saved_word}, 0);
    running = 1;

    // R1 flag unit update
    flag_upd = 1; flag_in = 5'b10101; step();
    // supervisor full write with reserved bits set (R2), master stack, trace 10
    wr_full = 1; wr_data = 16'hB5FF; step();
    sp_wr = 1; sp_wdata = 32'h0000_A000; step();
    // switch to interrupt stack while writing: old bank gets data (R7)
    wr_full = 1; wr_data = 16'h2300; sp_wr = 1; sp_wdata = 32'h0000_B000; step();
    sp_wr = 1; sp_wdata = 32'h0000_C000; step();
    // trace 11 stored, not acted on (R5)
    wr_full = 1; wr_data = 16'hE100; step();
    @(negedge clk);
    chk("R5 illegal trace", {trace_illegal, trace_mode}, 3'b100);
    // drop to user, trace 01
    wr_full = 1; wr_data = 16'h4005; step();
    sp_wr = 1; sp_wdata = 32'h0000_D000; step();
    // R6 user full write refused
    wr_full = 1; wr_data = 16'h2700; step();
    chk("R6 viol pulse", priv_viol, 1);
    chk("R6 unchanged", status_word, 16'h4005);
    @(negedge clk);
    chk("R6 pulse one cycle", priv_viol, 0);
    // R12 low byte allowed in user
    wr_low = 1; wr_data = 16'hFFEA; step();
    chk("R12 low write", status_word, 16'h400A);
    // R10 user return refused
    exc_return = 1; ret_word = 16'h2000; step();
    chk("R10 user return", {priv_viol, status_word}, {1'b1, 16'h400A});
    // R8/R9 entry from user with simultaneous full write (R12)
    exc_enter = 1; wr_full = 1; wr_data = 16'h0000; step();
    chk("R8 entry word", status_word, 16'h200A);
    chk("R9 saved pre-entry", saved_word, 16'h400A);
    chk("R12 entry wins", priv_viol, 0);
    // R10 supervisor return restores
    exc_return = 1; ret_word = 16'h9FFF; step();
    chk("R10 restore", status_word, 16'h971F);
    @(negedge clk);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      exc_enter  = (r[3:0] == 0);
      exc_return = (r[7:4] == 0);
      wr_full    = (r[10:8] == 0);
      wr_low     = (r[13:11] == 0);
      flag_upd   = r[14];
      sp_wr      = r[15];
      wr_data    = 16'($urandom);
      ret_word   = 16'($urandom);
      flag_in    = 5'($urandom);
      sp_wdata   = $urandom;
      @(negedge clk);
    end
    idle();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule